// File: doc/BRIEF.md
# ADC Result Offset-Correction Formatter

This block sits between a successive-approximation converter core and the 16-bit result register. Each raw code arrives with a strobe, a polarity flag and a 2-bit resolution mode. The flag selects an unsigned single-ended code or a two's complement differential code. The block removes a signed offset-correction word from the code. It then limits the corrected value to the range that the active format can represent, and widens it to 16 bits. Single-ended results are widened with zeros and differential results with copies of the sign bit.

The result is registered and comes with a one-cycle valid pulse. A small two-state controller (`ST_IDLE`, `ST_PUBLISH`) drives the pulse. A strobe moves the controller to `ST_PUBLISH` on the next edge (transition *accept*). With no strobe it returns to `ST_IDLE` (transition *retire*). A strobe while in `ST_PUBLISH` keeps it there (transition *chain*), so strobes on consecutive cycles give consecutive results. The offset word is on the full 16-bit scale. It is shifted right arithmetically to match the active width before the subtraction.

Top module: `adc_ofs_formatter`

## Requirements
- R1: The code width W depends on the mode and polarity. Single-ended widths are 8, 12, 10 and 16 for modes 0, 1, 2 and 3. Differential widths are 9, 13, 11 and 16 for the same modes.
- R2: Bits of `raw_code` at positions W and above have no effect on the result.
- R3: In single-ended mode `raw_code[W-1:0]` is read as unsigned. In differential mode it is read as W-bit two's complement.
- R4: `ofs_word` is a signed 16-bit value. It is arithmetically shifted right by 16-W and then subtracted from the code.
- R5: In single-ended mode a corrected value below 0 becomes 0, and a value above 2^W-1 becomes 2^W-1.
- R6: In differential mode a corrected value below -2^(W-1) becomes -2^(W-1), and a value above 2^(W-1)-1 becomes 2^(W-1)-1.
- R7: Single-ended results are zero-extended to 16 bits. Differential results are sign-extended to 16 bits.
- R8: `res_data` and `res_valid` change on the clock edge that samples `code_valid` high. `res_valid` is high for exactly one cycle per strobe, and strobes on consecutive cycles give pulses on consecutive cycles.
- R9: With `code_valid` low, `res_data` keeps its last value and `res_valid` is low, whatever the other inputs do.
- R10: After reset `res_valid` is 0 and `res_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | Strobe: the inputs below carry a conversion |
| code_diff | input | 1 | 1 = differential code, 0 = single-ended |
| code_mode | input | 2 | Resolution mode |
| raw_code | input | 16 | Raw converter code, right-aligned |
| ofs_word | input | 16 | Signed offset correction on the 16-bit scale |
| res_valid | output | 1 | One-cycle pulse with each new result |
| res_data | output | 16 | Corrected, limited and extended result |

## Verification
Every result is due one edge after its strobe is sampled, and nothing in the data path adds latency. The bench changes inputs on the falling edge and compares `res_valid` and `res_data` on the following falling edge, half a period after the capturing edge. In the back-to-back sequence, each result is checked on the falling edge at which the next code is driven. The hold checks sample again on the falling edges after the strobe drops, while the other inputs are changed.

// File: rtl/ofc_pkg.sv
`timescale 1ns/1ps
package ofc_pkg;
    localparam int DATA_W = 16;
    localparam int ACC_W  = DATA_W + 2;
    localparam int WID_W  = $clog2(DATA_W + 1);

    // single-ended widths per mode; differential adds one bit except at full width
    localparam int SE_W0 = 8;
    localparam int SE_W1 = 12;
    localparam int SE_W2 = 10;
    localparam int SE_W3 = DATA_W;

    typedef enum logic [1:0] {
        RES_NARROW = 2'd0,
        RES_WIDE   = 2'd1,
        RES_MID    = 2'd2,
        RES_FULL   = 2'd3
    } res_mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PUBLISH = 1'b1
    } pub_state_e;
endpackage

// File: rtl/ofc_width_dec.sv
`timescale 1ns/1ps
module ofc_width_dec
    import ofc_pkg::*;
(
    input  logic             diff,
    input  logic [1:0]       mode,
    output logic [WID_W-1:0] width,
    output logic [WID_W-1:0] shift
);
    logic [WID_W-1:0] base;

    always_comb begin
        unique case (res_mode_e'(mode))
            RES_NARROW: base = WID_W'(SE_W0);
            RES_WIDE:   base = WID_W'(SE_W1);
            RES_MID:    base = WID_W'(SE_W2);
            RES_FULL:   base = WID_W'(SE_W3);
            default:    base = WID_W'(SE_W0);
        endcase
        width = (diff && base != WID_W'(DATA_W)) ? base + WID_W'(1) : base;
        shift = WID_W'(DATA_W) - width;
    end

    // R1
    always_comb begin
        width_legal_chk: assert (width >= WID_W'(SE_W0) && width <= WID_W'(DATA_W));
    end
endmodule

// File: rtl/ofc_subtract.sv
`timescale 1ns/1ps
module ofc_subtract
    import ofc_pkg::*;
(
    input  logic                    diff,
    input  logic [WID_W-1:0]        width,
    input  logic [WID_W-1:0]        shift,
    input  logic [DATA_W-1:0]       raw,
    input  logic [DATA_W-1:0]       ofs,
    output logic signed [ACC_W-1:0] corrected
);
    logic                    sign_bit;
    logic [DATA_W-1:0]       code_ext;
    logic signed [ACC_W-1:0] code_s;
    logic signed [ACC_W-1:0] ofs_s;
    logic signed [ACC_W-1:0] ofs_scaled;

    always_comb begin
        sign_bit = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i == int'(width) - 1) sign_bit = raw[i];
        end
    end

    // bits at or above the active width are replaced, never passed through
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign code_ext[g] = (WID_W'(g) < width) ? raw[g] : (diff & sign_bit);
    end

    always_comb begin
        code_s     = {{(ACC_W-DATA_W){diff & code_ext[DATA_W-1]}}, code_ext};
        ofs_s      = {{(ACC_W-DATA_W){ofs[DATA_W-1]}}, ofs};
        ofs_scaled = ofs_s >>> shift;
        corrected  = code_s - ofs_scaled;
    end
endmodule

// File: rtl/ofc_clamp.sv
`timescale 1ns/1ps
module ofc_clamp
    import ofc_pkg::*;
(
    input  logic                    diff,
    input  logic [WID_W-1:0]        width,
    input  logic signed [ACC_W-1:0] value,
    output logic [DATA_W-1:0]       result
);
    localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1);

    logic signed [ACC_W-1:0] lim_hi;
    logic signed [ACC_W-1:0] lim_lo;
    logic signed [ACC_W-1:0] limited;

    always_comb begin
        if (diff) begin
            lim_hi = (ONE << (width - WID_W'(1))) - ONE;
            lim_lo = -(ONE << (width - WID_W'(1)));
        end else begin
            lim_hi = (ONE << width) - ONE;
            lim_lo = '0;
        end
        if (value > lim_hi)      limited = lim_hi;
        else if (value < lim_lo) limited = lim_lo;
        else                     limited = value;
        result = limited[DATA_W-1:0];
    end

    // R5 R6
    always_comb begin
        clamp_range_chk: assert (limited <= lim_hi && limited >= lim_lo);
    end
endmodule

// File: rtl/adc_ofs_formatter.sv
`timescale 1ns/1ps
module adc_ofs_formatter
    import ofc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic              code_diff,
    input  logic [1:0]        code_mode,
    input  logic [DATA_W-1:0] raw_code,
    input  logic [DATA_W-1:0] ofs_word,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    logic [WID_W-1:0]        width;
    logic [WID_W-1:0]        shift;
    logic signed [ACC_W-1:0] corrected;
    logic [DATA_W-1:0]       formatted;
    pub_state_e              state_q, state_d;

    ofc_width_dec u_width (
        .diff  (code_diff),
        .mode  (code_mode),
        .width (width),
        .shift (shift)
    );

    ofc_subtract u_sub (
        .diff      (code_diff),
        .width     (width),
        .shift     (shift),
        .raw       (raw_code),
        .ofs       (ofs_word),
        .corrected (corrected)
    );

    ofc_clamp u_clamp (
        .diff   (code_diff),
        .width  (width),
        .value  (corrected),
        .result (formatted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = code_valid ? ST_PUBLISH : ST_IDLE;
            ST_PUBLISH: state_d = code_valid ? ST_PUBLISH : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        res_valid = (state_q == ST_PUBLISH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          res_data <= '0;
        else if (code_valid) res_data <= formatted;
    end

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(code_valid));

    // R8
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> res_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |=> ($stable(res_data) && !res_valid));
endmodule

// File: tb/tb_adc_ofs_formatter.sv
`timescale 1ns/1ps
module tb_adc_ofs_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_valid = 1'b0;
    logic        code_diff = 1'b0;
    logic [1:0]  code_mode = 2'd0;
    logic [15:0] raw_code = '0;
    logic [15:0] ofs_word = '0;
    logic        res_valid;
    logic [15:0] res_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    adc_ofs_formatter dut (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_diff(code_diff),
        .code_mode(code_mode), .raw_code(raw_code), .ofs_word(ofs_word),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic int width_of(input bit d, input int m);
        int se;
        case (m)
            0: se = 8;
            1: se = 12;
            2: se = 10;
            default: se = 16;
        endcase
        return (d && se != 16) ? se + 1 : se;
    endfunction

    function automatic logic [15:0] model(input bit d, input int m,
                                          input logic [15:0] raw, input logic [15:0] ofs);
        int w = width_of(d, m);
        int v = int'(raw) & ((1 << w) - 1);
        int o = int'($signed(ofs));
        int c, hi, lo;
        if (d && v >= (1 << (w - 1))) v = v - (1 << w);
        o = o >>> (16 - w);
        c = v - o;
        hi = d ? (1 << (w - 1)) - 1 : (1 << w) - 1;
        lo = d ? -(1 << (w - 1)) : 0;
        if (c > hi) c = hi;
        if (c < lo) c = lo;
        return c[15:0];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input bit d, input int m, input logic [15:0] raw, input logic [15:0] ofs);
        code_valid = 1'b1;
        code_diff  = d;
        code_mode  = 2'(m);
        raw_code   = raw;
        ofs_word   = ofs;
    endtask

    task automatic send(input string req, input bit d, input int m,
                        input logic [15:0] raw, input logic [15:0] ofs, input logic [15:0] exp);
        @(negedge clk);
        drive(d, m, raw, ofs);
        @(negedge clk);
        check({req, " valid"}, 16'(res_valid), 16'd1);
        check(req, res_data, exp);
        code_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 valid", 16'(res_valid), 16'd0);
        check("R10 data", res_data, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 valid after release", 16'(res_valid), 16'd0);

        // R1 R3 plain single-ended, mode 0, no offset
        send("R1 R3 se8", 0, 0, 16'h00F0, 16'h0000, 16'h00F0);
        // R4 offset 0x1000 scaled by >>8 gives 16
        send("R4 se8 ofs", 0, 0, 16'h00F0, 16'h1000, 16'h00E0);
        // R5 negative corrected value limited to 0
        send("R5 se8 floor", 0, 0, 16'h0005, 16'h0A00, 16'h0000);
        // R5 full width overflow limited to 0xFFFF
        send("R5 se16 ceil", 0, 3, 16'hFFF0, 16'hFF00, 16'hFFFF);
        // R6 differential 9-bit floor: -256 - 2 -> -256
        send("R6 diff9 floor", 1, 0, 16'h0100, 16'h0100, 16'hFF00);
        // R6 differential 13-bit ceiling: 4095 + 1 -> 4095
        send("R6 diff13 ceil", 1, 1, 16'h0FFF, 16'hFFF8, 16'h0FFF);
        // R7 R3 differential 11-bit negative sign-extended
        send("R7 diff11 sext", 1, 2, 16'h07F6, 16'h0000, 16'hFFF6);
        // R2 garbage above 10 bits ignored
        send("R2 se10 upper", 0, 2, 16'hFC05, 16'h0000, 16'h0005);
        // R2 differential 9-bit with garbage above
        send("R2 diff9 upper", 1, 0, 16'hAE01, 16'h0000, 16'h0001);
        // R1 single-ended 12-bit max passes through
        send("R1 se12 max", 0, 1, 16'h0FFF, 16'h0000, 16'h0FFF);
        // R7 differential full width most negative
        send("R7 diff16 min", 1, 3, 16'h8000, 16'h0001, 16'h8000);

        // R9 hold while strobe low, inputs churning
        held = res_data;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            code_diff = k[0];
            code_mode = 2'(k);
            raw_code  = 16'(k * 16'h1357);
            ofs_word  = 16'(k * 16'h0F0F);
            @(negedge clk);
            check("R9 hold data", res_data, held);
            check("R9 hold valid", 16'(res_valid), 16'd0);
        end

        // R8 back-to-back strobes
        @(negedge clk);
        drive(0, 0, 16'h0011, 16'h0000);
        @(negedge clk);
        check("R8 b2b valid a", 16'(res_valid), 16'd1);
        check("R8 b2b data a", res_data, 16'h0011);
        drive(0, 0, 16'h0022, 16'h0000);
        @(negedge clk);
        check("R8 b2b valid b", 16'(res_valid), 16'd1);
        check("R8 b2b data b", res_data, 16'h0022);
        code_valid = 1'b0;
        @(negedge clk);
        check("R8 pulse ends", 16'(res_valid), 16'd0);

        // random sweep against the model
        for (int n = 0; n < 600; n++) begin
            bit d = 1'($urandom);
            int m = int'($urandom % 4);
            logic [15:0] r = 16'($urandom);
            logic [15:0] o;
            case ($urandom % 4)
                0: o = 16'h0000;
                1: o = 16'h7FFF;
                2: o = 16'h8000;
                default: o = 16'($urandom);
            endcase
            send("R4 R5 R6 R7 random", d, m, r, o, model(d, m, r, o));
            if (n % 7 == 0) begin
                @(negedge clk);
                check("R8 single pulse", 16'(res_valid), 16'd0);
            end
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule